// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits next to a processor core's program counter and status register. It handles two events. The first is taking an exception or interrupt. It stores the interrupted PC and status word and records the event code in one of three event registers. For trap and memory-fault events it also captures the trap immediate or the faulting address. The core is then sent to a vector address with its status word changed to blocked, privileged and alternate-bank. The second event is the return from a handler, which sends the core back to the stored PC and status word.

All updates for an entry happen on one accepting clock edge. In the cycle after that edge a one-cycle `redirect` strobe is raised, carrying the PC and status word the core must load. The block also tells the requester whether a new exception can be taken now. Acceptance is refused while the incoming status word has its block bit set, and also during the redirect cycle of an entry, because the core has not yet loaded the blocked status. Either refusal is overridden when nested acceptance is enabled.

Top module: `exc_seq`

## Requirements
- R1: When an exception is accepted, `saved_pc` takes `cur_pc` and `saved_sr` takes `cur_sr` on that clock edge.
- R2: In the cycle after acceptance, `redirect` is 1 and `new_sr` has the block bit (bit 28) set.
- R3: In that same cycle, `new_sr` also has the privilege bit (bit 30) and the bank bit (bit 29) set. Every other bit equals the accepted `cur_sr`.
- R4: The event code goes into bits 11:0 of one event register, chosen by `exc_kind`: 2'b00 selects `ev_general`, 2'b01 selects `ev_irq`, and 2'b10 or 2'b11 select `ev_irq2`. Bits 31:12 of every event register are always 0, and the two registers that were not selected keep their values.
- R5: An accepted exception with `exc_is_trap`=1 loads `trap_reg` with the 8-bit immediate, zero-extended. In every other case `trap_reg` keeps its value.
- R6: An accepted exception with `exc_is_fault`=1 loads `fault_reg` with `fault_addr`. In every other case `fault_reg` keeps its value.
- R7: On an entry redirect, `new_pc` equals the sum of `vec_base` and `vec_off` as they were in the accepting cycle.
- R8: `accept_ok` is 1 when `multi_en` is 1. When `multi_en` is 0, `accept_ok` is 1 only if `cur_sr` bit 28 is 0 and the current cycle is not an entry redirect cycle. A request made while `accept_ok` is 0 changes no register.
- R9: A return command that is not displaced by an exception gives `redirect`=1 in the next cycle, with `new_pc` equal to `saved_pc` and `new_sr` equal to `saved_sr` as held before that edge.
- R10: When a request and a return arrive in the same cycle, an accepted exception wins and the return is dropped. If the exception is refused, the return is carried out.
- R11: `redirect` is high for exactly one cycle per accepted event. In a cycle with neither event, it falls the next cycle and `new_pc` and `new_sr` keep their values.
- R12: During reset every register output is 0 and `redirect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_sr | input | 32 | Current status word |
| vec_base | input | 32 | Vector base address |
| vec_off | input | 32 | Offset for this event's class |
| exc_req | input | 1 | Exception or interrupt request |
| exc_kind | input | 2 | Event class: general, interrupt, or second interrupt |
| exc_code | input | 12 | Event code |
| exc_is_trap | input | 1 | Event is a trap instruction |
| trap_imm | input | 8 | Trap immediate |
| exc_is_fault | input | 1 | Event is a memory-access fault |
| fault_addr | input | 32 | Faulting logical address |
| multi_en | input | 1 | Allow nested acceptance |
| rte_req | input | 1 | Return-from-exception command |
| accept_ok | output | 1 | A request would be accepted this cycle |
| redirect | output | 1 | One-cycle strobe to load new_pc and new_sr |
| new_pc | output | 32 | PC for the core to load |
| new_sr | output | 32 | Status word for the core to load |
| saved_pc | output | 32 | Saved PC |
| saved_sr | output | 32 | Saved status word |
| ev_general | output | 32 | General exception event register |
| ev_irq | output | 32 | Interrupt event register |
| ev_irq2 | output | 32 | Second interrupt event register |
| trap_reg | output | 32 | Trap immediate register |
| fault_reg | output | 32 | Fault address register |

## Verification
The hardest case to reach is a request that arrives in the redirect cycle of a previous entry, while `cur_sr` still shows the block bit clear. Refusing it relies only on internal state, and that state interacts with `multi_en` and with a return command in the same cycle. The stimulus holds the block bit clear most of the time and issues requests densely, often on consecutive cycles. This makes request-in-redirect-cycle collisions, with and without `multi_en` and together with `rte_req`, occur many times. A behavioural model checks every output on every cycle.

// File: rtl/exc_seq_pkg.sv
// Shared types and helpers for the exception sequencer.
// Assumes three event registers: general, interrupt, second interrupt.
package exc_seq_pkg;
    typedef enum logic [1:0] {
        EK_GENERAL = 2'b00,
        EK_IRQ     = 2'b01,
        EK_IRQ2    = 2'b10,
        EK_IRQ2B   = 2'b11
    } exc_kind_e;

    localparam int NUM_EV = 3;

    // Map an event class to the index of its event register.
    function automatic int unsigned ev_index(input logic [1:0] kind);
        case (kind)
            EK_GENERAL: return 0;
            EK_IRQ:     return 1;
            default:    return 2;
        endcase
    endfunction
endpackage

// File: rtl/exc_seq_gate.sv
// Acceptance gate: decides whether an exception or a return is taken.
// Assumes sr_bl is the block bit of the incoming status word and that
// entry_busy is high during the redirect cycle of an entry.
module exc_seq_gate (
    input  logic exc_req,
    input  logic rte_req,
    input  logic sr_bl,
    input  logic multi_en,
    input  logic entry_busy,
    output logic accept_ok,
    output logic take_exc,
    output logic take_rte
);
    // Combine the mask conditions and give an accepted exception priority.
    always_comb begin
        accept_ok = multi_en || (!sr_bl && !entry_busy);
        take_exc  = exc_req && accept_ok;
        take_rte  = rte_req && !take_exc;
    end
endmodule

// File: rtl/exc_seq_store.sv
// Saved-state and event-record registers, all updated on an accepted entry.
// Assumes take_exc lasts exactly one cycle per accepted event.
module exc_seq_store #(
    parameter int REG_W  = 32,
    parameter int CODE_W = 12,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_exc,
    input  logic [REG_W-1:0]  cur_pc,
    input  logic [REG_W-1:0]  cur_sr,
    input  logic [1:0]        exc_kind,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_is_trap,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic              exc_is_fault,
    input  logic [REG_W-1:0]  fault_addr,
    output logic [REG_W-1:0]  saved_pc,
    output logic [REG_W-1:0]  saved_sr,
    output logic [exc_seq_pkg::NUM_EV*REG_W-1:0] ev_flat,
    output logic [REG_W-1:0]  trap_reg,
    output logic [REG_W-1:0]  fault_reg
);
    import exc_seq_pkg::*;

    localparam int CODE_PAD = REG_W - CODE_W;
    localparam int IMM_PAD  = REG_W - IMM_W;

    // Capture the interrupted PC and status word on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_pc <= '0;
            saved_sr <= '0;
        end else if (take_exc) begin
            saved_pc <= cur_pc;
            saved_sr <= cur_sr;
        end
    end

    // One event register per class; only the selected one is written.
    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        logic [REG_W-1:0] q;
        // Record the zero-extended code when this class is chosen.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (take_exc && (ev_index(exc_kind) == g))
                q <= {{CODE_PAD{1'b0}}, exc_code};
        end
        assign ev_flat[g*REG_W +: REG_W] = q;
    end

    // Trap immediate: loaded only for trap events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trap_reg <= '0;
        else if (take_exc && exc_is_trap)
            trap_reg <= {{IMM_PAD{1'b0}}, trap_imm};
    end

    // Faulting address: loaded only for memory-access faults.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_reg <= '0;
        else if (take_exc && exc_is_fault)
            fault_reg <= fault_addr;
    end
endmodule

// File: rtl/exc_seq_redirect.sv
// Output stage: registers the PC and status word handed back to the core,
// with a one-cycle strobe. Assumes take_exc and take_rte are exclusive.
module exc_seq_redirect #(
    parameter int REG_W = 32,
    parameter int BL_B  = 28,
    parameter int RB_B  = 29,
    parameter int MD_B  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_exc,
    input  logic             take_rte,
    input  logic [REG_W-1:0] cur_sr,
    input  logic [REG_W-1:0] vec_base,
    input  logic [REG_W-1:0] vec_off,
    input  logic [REG_W-1:0] saved_pc,
    input  logic [REG_W-1:0] saved_sr,
    output logic             redirect,
    output logic             entry_busy,
    output logic [REG_W-1:0] new_pc,
    output logic [REG_W-1:0] new_sr
);
    localparam logic [REG_W-1:0] ENTRY_SET =
        (REG_W'(1) << BL_B) | (REG_W'(1) << RB_B) | (REG_W'(1) << MD_B);

    // Load the target PC and status word, and pulse the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect   <= 1'b0;
            entry_busy <= 1'b0;
            new_pc     <= '0;
            new_sr     <= '0;
        end else begin
            redirect   <= take_exc || take_rte;
            entry_busy <= take_exc;
            if (take_exc) begin
                new_pc <= vec_base + vec_off;
                new_sr <= cur_sr | ENTRY_SET;
            end else if (take_rte) begin
                new_pc <= saved_pc;
                new_sr <= saved_sr;
            end
        end
    end
endmodule

// File: rtl/exc_seq.sv
// Exception entry/return sequencer top. It connects the acceptance gate,
// the saved-state store and the redirect stage. Assumes the core loads
// new_pc and new_sr when redirect is high.
module exc_seq #(
    parameter int REG_W  = 32,
    parameter int CODE_W = 12,
    parameter int IMM_W  = 8,
    parameter int BL_B   = 28,
    parameter int RB_B   = 29,
    parameter int MD_B   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  cur_pc,
    input  logic [REG_W-1:0]  cur_sr,
    input  logic [REG_W-1:0]  vec_base,
    input  logic [REG_W-1:0]  vec_off,
    input  logic              exc_req,
    input  logic [1:0]        exc_kind,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_is_trap,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic              exc_is_fault,
    input  logic [REG_W-1:0]  fault_addr,
    input  logic              multi_en,
    input  logic              rte_req,
    output logic              accept_ok,
    output logic              redirect,
    output logic [REG_W-1:0]  new_pc,
    output logic [REG_W-1:0]  new_sr,
    output logic [REG_W-1:0]  saved_pc,
    output logic [REG_W-1:0]  saved_sr,
    output logic [REG_W-1:0]  ev_general,
    output logic [REG_W-1:0]  ev_irq,
    output logic [REG_W-1:0]  ev_irq2,
    output logic [REG_W-1:0]  trap_reg,
    output logic [REG_W-1:0]  fault_reg
);
    import exc_seq_pkg::*;

    logic take_exc;
    logic take_rte;
    logic entry_busy;
    logic [NUM_EV*REG_W-1:0] ev_flat;

    exc_seq_gate u_gate (
        .exc_req    (exc_req),
        .rte_req    (rte_req),
        .sr_bl      (cur_sr[BL_B]),
        .multi_en   (multi_en),
        .entry_busy (entry_busy),
        .accept_ok  (accept_ok),
        .take_exc   (take_exc),
        .take_rte   (take_rte)
    );

    exc_seq_store #(.REG_W(REG_W), .CODE_W(CODE_W), .IMM_W(IMM_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_exc     (take_exc),
        .cur_pc       (cur_pc),
        .cur_sr       (cur_sr),
        .exc_kind     (exc_kind),
        .exc_code     (exc_code),
        .exc_is_trap  (exc_is_trap),
        .trap_imm     (trap_imm),
        .exc_is_fault (exc_is_fault),
        .fault_addr   (fault_addr),
        .saved_pc     (saved_pc),
        .saved_sr     (saved_sr),
        .ev_flat      (ev_flat),
        .trap_reg     (trap_reg),
        .fault_reg    (fault_reg)
    );

    exc_seq_redirect #(.REG_W(REG_W), .BL_B(BL_B), .RB_B(RB_B), .MD_B(MD_B)) u_redir (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_exc   (take_exc),
        .take_rte   (take_rte),
        .cur_sr     (cur_sr),
        .vec_base   (vec_base),
        .vec_off    (vec_off),
        .saved_pc   (saved_pc),
        .saved_sr   (saved_sr),
        .redirect   (redirect),
        .entry_busy (entry_busy),
        .new_pc     (new_pc),
        .new_sr     (new_sr)
    );

    assign ev_general = ev_flat[0*REG_W +: REG_W];
    assign ev_irq     = ev_flat[1*REG_W +: REG_W];
    assign ev_irq2    = ev_flat[2*REG_W +: REG_W];
endmodule

// File: rtl/exc_seq_chk.sv
// Port-level property checker for exc_seq, attached with bind.
module exc_seq_chk #(
    parameter int REG_W  = 32,
    parameter int CODE_W = 12,
    parameter int BL_B   = 28,
    parameter int RB_B   = 29,
    parameter int MD_B   = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] cur_pc,
    input logic [REG_W-1:0] cur_sr,
    input logic [REG_W-1:0] vec_base,
    input logic [REG_W-1:0] vec_off,
    input logic             exc_req,
    input logic             exc_is_trap,
    input logic             exc_is_fault,
    input logic             rte_req,
    input logic             accept_ok,
    input logic             redirect,
    input logic [REG_W-1:0] new_pc,
    input logic [REG_W-1:0] new_sr,
    input logic [REG_W-1:0] saved_pc,
    input logic [REG_W-1:0] saved_sr,
    input logic [REG_W-1:0] ev_general,
    input logic [REG_W-1:0] ev_irq,
    input logic [REG_W-1:0] ev_irq2,
    input logic [REG_W-1:0] trap_reg,
    input logic [REG_W-1:0] fault_reg
);
    logic acc;
    assign acc = exc_req && accept_ok;

    p_save_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (saved_pc == $past(cur_pc)) && (saved_sr == $past(cur_sr)));
    p_block_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> redirect && new_sr[BL_B]);
    p_priv_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> new_sr[MD_B] && new_sr[RB_B]);
    p_ev_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_general[REG_W-1:CODE_W] == '0) && (ev_irq[REG_W-1:CODE_W] == '0)
        && (ev_irq2[REG_W-1:CODE_W] == '0));
    p_trap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && exc_is_trap) |=> $stable(trap_reg));
    p_fault_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && exc_is_fault) |=> $stable(fault_reg));
    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> new_pc == $past(vec_base) + $past(vec_off));
    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !accept_ok) |=> $stable(saved_pc) && $stable(saved_sr));
    p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_req && !acc) |=> redirect && (new_pc == $past(saved_pc))
        && (new_sr == $past(saved_sr)));
    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !rte_req) |=> !redirect && $stable(new_pc) && $stable(new_sr));
endmodule

bind exc_seq exc_seq_chk #(
    .REG_W(REG_W), .CODE_W(CODE_W), .BL_B(BL_B), .RB_B(RB_B), .MD_B(MD_B)
) i_exc_seq_chk (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_sr(cur_sr),
    .vec_base(vec_base), .vec_off(vec_off), .exc_req(exc_req),
    .exc_is_trap(exc_is_trap), .exc_is_fault(exc_is_fault),
    .rte_req(rte_req), .accept_ok(accept_ok), .redirect(redirect),
    .new_pc(new_pc), .new_sr(new_sr), .saved_pc(saved_pc),
    .saved_sr(saved_sr), .ev_general(ev_general), .ev_irq(ev_irq),
    .ev_irq2(ev_irq2), .trap_reg(trap_reg), .fault_reg(fault_reg)
);

// File: tb/test_exc_seq.sv
// Bench for exc_seq: behavioural reference model compared on every clock.
module test_exc_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, cur_sr = '0, vec_base = '0, vec_off = '0;
    logic        exc_req = 1'b0;
    logic [1:0]  exc_kind = '0;
    logic [11:0] exc_code = '0;
    logic        exc_is_trap = 1'b0;
    logic [7:0]  trap_imm = '0;
    logic        exc_is_fault = 1'b0;
    logic [31:0] fault_addr = '0;
    logic        multi_en = 1'b0;
    logic        rte_req = 1'b0;
    logic        accept_ok, redirect;
    logic [31:0] new_pc, new_sr, saved_pc, saved_sr;
    logic [31:0] ev_general, ev_irq, ev_irq2, trap_reg, fault_reg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_spc, m_ssr, m_tra, m_tea, m_npc, m_nsr;
    logic [31:0] m_ev [3];
    bit          m_red, m_busy;
    int          collide_cnt = 0;

    always #2 clk = ~clk;

    exc_seq i_exc_seq (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .vec_base(vec_base), .vec_off(vec_off), .exc_req(exc_req),
        .exc_kind(exc_kind), .exc_code(exc_code), .exc_is_trap(exc_is_trap),
        .trap_imm(trap_imm), .exc_is_fault(exc_is_fault),
        .fault_addr(fault_addr), .multi_en(multi_en), .rte_req(rte_req),
        .accept_ok(accept_ok), .redirect(redirect), .new_pc(new_pc),
        .new_sr(new_sr), .saved_pc(saved_pc), .saved_sr(saved_sr),
        .ev_general(ev_general), .ev_irq(ev_irq), .ev_irq2(ev_irq2),
        .trap_reg(trap_reg), .fault_reg(fault_reg)
    );

    function automatic bit model_ok();
        return multi_en || (!cur_sr[28] && !m_busy);
    endfunction

    // Model update at each rising edge, from inputs that are stable there.
    always @(posedge clk) begin
        bit take_e;
        bit take_r;
        logic [31:0] old_spc;
        logic [31:0] old_ssr;
        if (!rst_n) begin
            m_spc = 0; m_ssr = 0; m_tra = 0; m_tea = 0; m_npc = 0; m_nsr = 0;
            for (int k = 0; k < 3; k++) m_ev[k] = 0;
            m_red = 0; m_busy = 0;
        end else begin
            take_e = exc_req && model_ok();
            take_r = rte_req && !take_e;
            if (exc_req && rte_req) collide_cnt++;
            old_spc = m_spc; old_ssr = m_ssr;
            m_red = take_e || take_r;
            m_busy = take_e;
            if (take_e) begin
                m_spc = cur_pc; m_ssr = cur_sr;
                m_ev[(exc_kind == 2'b00) ? 0 : (exc_kind == 2'b01) ? 1 : 2] = {20'd0, exc_code};
                if (exc_is_trap) m_tra = {24'd0, trap_imm};
                if (exc_is_fault) m_tea = fault_addr;
                m_npc = vec_base + vec_off;
                m_nsr = cur_sr | 32'h7000_0000;
            end else if (take_r) begin
                m_npc = old_spc; m_nsr = old_ssr;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            if (!rst_n) chk("R12 reset redirect", {31'd0, redirect}, 32'd0);
            chk("R1 saved_pc", saved_pc, m_spc);
            chk("R1 saved_sr", saved_sr, m_ssr);
            chk("R11 redirect strobe", {31'd0, redirect}, {31'd0, m_red});
            chk("R2 R3 R9 new_sr", new_sr, m_nsr);
            chk("R7 R9 new_pc", new_pc, m_npc);
            chk("R4 ev_general", ev_general, m_ev[0]);
            chk("R4 ev_irq", ev_irq, m_ev[1]);
            chk("R4 ev_irq2", ev_irq2, m_ev[2]);
            chk("R5 trap_reg", trap_reg, m_tra);
            chk("R6 fault_reg", fault_reg, m_tea);
            if (rst_n) chk("R8 accept_ok", {31'd0, accept_ok}, {31'd0, model_ok()});
        end
    end

    task automatic drive_idle();
        exc_req = 0; rte_req = 0; exc_is_trap = 0; exc_is_fault = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Directed: entry with block bit clear, then a request in the redirect cycle (R8).
        @(negedge clk);
        cur_pc = 32'h0000_1000; cur_sr = 32'h0000_00F0; vec_base = 32'h8000_0000;
        vec_off = 32'h100; exc_req = 1; exc_kind = 2'b00; exc_code = 12'hABC;
        exc_is_trap = 1; trap_imm = 8'h5A; exc_is_fault = 1; fault_addr = 32'hDEAD_BEE0;
        @(negedge clk);
        exc_kind = 2'b01; exc_code = 12'h123; exc_is_trap = 0; exc_is_fault = 0;
        @(negedge clk);
        // Collision with block bit set: return must run (R10).
        cur_sr = 32'h1000_0000; rte_req = 1; exc_req = 1; exc_kind = 2'b10;
        @(negedge clk);
        // Collision with nesting enabled: exception wins (R10).
        multi_en = 1; cur_pc = 32'h2222_0000;
        @(negedge clk);
        drive_idle(); multi_en = 0; cur_sr = 32'h0;
        repeat (2) @(negedge clk);
        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            cur_pc       = $urandom;
            cur_sr       = ($urandom_range(0, 9) < 3) ? ($urandom | 32'h1000_0000)
                                                      : ($urandom & 32'hEFFF_FFFF);
            vec_base     = $urandom;
            vec_off      = $urandom_range(0, 4095);
            exc_req      = ($urandom_range(0, 9) < 5);
            exc_kind     = 2'($urandom);
            exc_code     = 12'($urandom);
            exc_is_trap  = $urandom_range(0, 1) == 1;
            trap_imm     = 8'($urandom);
            exc_is_fault = $urandom_range(0, 1) == 1;
            fault_addr   = $urandom;
            multi_en     = ($urandom_range(0, 9) < 2);
            rte_req      = ($urandom_range(0, 9) < 3);
            if (i == 2000) rst_n = 1'b0;
            if (i == 2003) rst_n = 1'b1;
            @(negedge clk);
        end
        drive_idle();
        repeat (3) @(negedge clk);
        checks++;
        if (collide_cnt == 0) begin
            failures++;
            $display("FAIL R10 collisions actual=%0d expected=>0", collide_cnt);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule